// File: doc/BRIEF.md
# Diagonal Syndrome Discrepancy Engine

This block produces the discrepancy of one error-locator candidate against the syndrome sequence during a single iteration of a Berlekamp-Massey-style decoder for codes over GF(16). The caller loads syndromes and locator coefficients through a write port. Each value goes to one of Q row memories, chosen by its index modulo Q, at the row address given by the index divided by Q. The caller then pulses `start` with the iteration index `iter_l` and the locator order `order_o`. The engine sweeps the syndrome memories downwards from row address `iter_l / Q`. Each coefficient memory follows its own address offset by the span `c = iter_l - order_o`. Every clock it forms Q field products, sums them with XOR and adds the sum into an accumulator.

There is no storage for the zero terms outside the valid range. A coefficient lane whose address is negative reads as zero. Syndrome lanes above `iter_l` are masked in the first step. The coefficient lanes pass through a registered cyclic rotator, turned by `c mod Q`, so each lane meets the syndrome it must be multiplied with. When the sweep ends and the pipeline drains, `done` pulses for one cycle and the result appears on `disc`.

Top module: `dd_disc_unit`

## Requirements
- R1: While reset is held and after it is released with no start, `busy`, `done` and `disc` are all 0.
- R2: Field arithmetic is GF(2^4) with the reduction polynomial x^4+x+1 and XOR as addition; for example, a coefficient 0x2 times a syndrome 0x9 gives 0x1.
- R3: The result equals the XOR over k = 0..order_o of b[k]·S[c+k], with c = iter_l − order_o and 0 ≤ order_o ≤ iter_l < Q·DEPTH. The coefficient rotation amount stays fixed for the whole iteration.
- R4: A write with `wr_coef`=1 stores `wr_data` as coefficient b[`wr_idx`], and one with `wr_coef`=0 stores it as syndrome S[`wr_idx`]. Index i sits in row i mod Q at row address i div Q.
- R5: Stored coefficients with index above `order_o`, and stored syndromes with index above `iter_l`, have no effect on the result.
- R6: Lanes whose coefficient index c+k−c falls below zero (negative memory address) contribute zero, so syndromes below index c have no effect.
- R7: `done` is high for exactly one cycle per iteration. `disc` holds its value from one `done` to the next.
- R8: `busy` rises on the cycle after an accepted `start` and falls when `done` rises. A `start` while `busy` is high is ignored.
- R9: The boundary iterations `order_o`=0, `order_o`=`iter_l`, and `iter_l`=Q·DEPTH−1 give the R3 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Memory write strobe |
| wr_coef | input | 1 | 1 selects coefficient memory, 0 selects syndrome memory |
| wr_idx | input | log2(Q·DEPTH) | Linear index of the written value |
| wr_data | input | 4 | Field element to write |
| start | input | 1 | Begin an iteration (accepted only when idle) |
| iter_l | input | log2(Q·DEPTH) | Iteration index l |
| order_o | input | log2(Q·DEPTH) | Locator order o(b) |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle result strobe |
| disc | output | 4 | Discrepancy of the last iteration |

## Verification
The main function is driven with pseudo-random memory contents and a table of (l, o) pairs. Spans that are multiples of Q separate a correct rotation from a missing one. Spans with residues 1 to 3 expose off-by-one rotation direction. Values of l mod Q from 0 to 3 test the first-step mask on syndromes above l. A single-term case with known operands isolates the field multiplier from the sweep. Rewriting coefficients beyond o and syndromes beyond l, then repeating an iteration, shows whether any masked lane leaks into the sum.

// File: rtl/dd_pkg.sv
package dd_pkg;
    localparam int GF_M = 4;
    localparam logic [GF_M:0] GF_POLY = 5'b10011;

    typedef logic [GF_M-1:0] gf_t;
    typedef logic [2*GF_M-2:0] gf_prod_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } dd_state_e;

    // Carry-less product followed by polynomial reduction.
    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_prod_t p;
        p = '0;
        for (int i = 0; i < GF_M; i++) begin
            if (b[i]) p = p ^ (gf_prod_t'(a) << i);
        end
        for (int j = 2*GF_M-2; j >= GF_M; j--) begin
            if (p[j]) p = p ^ (gf_prod_t'(GF_POLY) << (j - GF_M));
        end
        return p[GF_M-1:0];
    endfunction
endpackage

// File: rtl/dd_row_mem.sv
module dd_row_mem
    import dd_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH) + 2
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  gf_t                      wr_data,
    input  logic [AW-1:0]            rd_addr,
    output gf_t                      rd_data
);
    localparam int DW = $clog2(DEPTH);

    gf_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // Negative (or out-of-range) addresses read as the field zero.
    always_comb begin
        if (rd_addr[AW-1] || (rd_addr[AW-2:DW] != '0)) rd_data = '0;
        else                                           rd_data = mem_q[rd_addr[DW-1:0]];
    end
endmodule

// File: rtl/dd_lane_rot.sv
module dd_lane_rot
    import dd_pkg::*;
#(
    parameter int Q = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [$clog2(Q)-1:0]     amt,
    input  logic [Q-1:0][GF_M-1:0]   din,
    output logic [Q-1:0][GF_M-1:0]   dout
);
    localparam int QB = $clog2(Q);

    logic [Q-1:0][GF_M-1:0] rot_d, rot_q;

    always_comb begin
        rot_d = rot_q;
        if (en) begin
            for (int r = 0; r < Q; r++) begin
                rot_d[r] = din[QB'(r) - amt];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rot_q <= '0;
        else        rot_q <= rot_d;
    end

    assign dout = rot_q;
endmodule

// File: rtl/dd_lane_dot.sv
module dd_lane_dot
    import dd_pkg::*;
#(
    parameter int Q = 4
) (
    input  logic [Q-1:0][GF_M-1:0] syn,
    input  logic [Q-1:0][GF_M-1:0] coef,
    output gf_t                    sum
);
    always_comb begin
        sum = '0;
        for (int r = 0; r < Q; r++) begin
            sum = sum ^ gf_mul(coef[r], syn[r]);
        end
    end
endmodule

// File: rtl/dd_disc_unit.sv
module dd_disc_unit
    import dd_pkg::*;
#(
    parameter int Q     = 4,
    parameter int DEPTH = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             wr_coef,
    input  logic [$clog2(Q*DEPTH)-1:0]       wr_idx,
    input  logic [3:0]                       wr_data,
    input  logic                             start,
    input  logic [$clog2(Q*DEPTH)-1:0]       iter_l,
    input  logic [$clog2(Q*DEPTH)-1:0]       order_o,
    output logic                             busy,
    output logic                             done,
    output logic [3:0]                       disc
);
    localparam int QB = $clog2(Q);
    localparam int DW = $clog2(DEPTH);
    localparam int IW = QB + DW;
    localparam int AW = DW + 2;

    typedef struct packed {
        dd_state_e              st;
        logic                   busy;
        logic                   done;
        logic                   first;
        logic [QB-1:0]          lmod;
        logic [QB-1:0]          cm;
        logic [AW-1:0]          syn_addr;
        logic [Q-1:0][AW-1:0]   coef_addr;
        logic                   v1;
        logic [Q-1:0][GF_M-1:0] syn1;
        logic [Q-1:0][GF_M-1:0] coef1;
        logic                   v2;
        logic [Q-1:0][GF_M-1:0] syn2;
        gf_t                    acc;
        gf_t                    disc;
    } dd_regs_t;

    dd_regs_t r_d, r_q;

    logic [Q-1:0][GF_M-1:0] syn_rd;
    logic [Q-1:0][GF_M-1:0] coef_rd;
    logic [Q-1:0][GF_M-1:0] coef2;
    logic [QB-1:0]          rot_amt;
    gf_t                    lane_sum;

    assign rot_amt = r_q.cm;

    // Row memories: index i lives in row i mod Q at address i div Q.
    for (genvar g = 0; g < Q; g++) begin : g_row
        dd_row_mem #(.DEPTH(DEPTH), .AW(AW)) u_syn (
            .clk     (clk),
            .wr_en   (wr_en && !wr_coef && (wr_idx[QB-1:0] == QB'(g))),
            .wr_addr (wr_idx[IW-1:QB]),
            .wr_data (wr_data),
            .rd_addr (r_q.syn_addr),
            .rd_data (syn_rd[g])
        );
        dd_row_mem #(.DEPTH(DEPTH), .AW(AW)) u_coef (
            .clk     (clk),
            .wr_en   (wr_en && wr_coef && (wr_idx[QB-1:0] == QB'(g))),
            .wr_addr (wr_idx[IW-1:QB]),
            .wr_data (wr_data),
            .rd_addr (r_q.coef_addr[g]),
            .rd_data (coef_rd[g])
        );
    end

    dd_lane_rot #(.Q(Q)) u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.v1),
        .amt   (rot_amt),
        .din   (r_q.coef1),
        .dout  (coef2)
    );

    dd_lane_dot #(.Q(Q)) u_dot (
        .syn  (r_q.syn2),
        .coef (coef2),
        .sum  (lane_sum)
    );

    always_comb begin
        logic [IW-1:0] span;
        logic [QB-1:0] rr;
        logic          any_live;
        int            kk;

        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.v1   = 1'b0;
        span     = iter_l - order_o;
        any_live = 1'b0;
        for (int r = 0; r < Q; r++) begin
            if (!r_q.coef_addr[r][AW-1]) any_live = 1'b1;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st       = ST_RUN;
                    r_d.busy     = 1'b1;
                    r_d.first    = 1'b1;
                    r_d.acc      = '0;
                    r_d.lmod     = iter_l[QB-1:0];
                    r_d.cm       = span[QB-1:0];
                    r_d.syn_addr = AW'(int'(iter_l) >>> QB);
                    // Coefficient row r' pairs with syndrome row (r' + c) mod Q.
                    for (int r = 0; r < Q; r++) begin
                        rr = QB'(r) + span[QB-1:0];
                        kk = ((int'(iter_l) >>> QB) <<< QB) + int'(rr) - int'(span);
                        r_d.coef_addr[r] = AW'(kk >>> QB);
                    end
                end
            end
            ST_RUN: begin
                if (any_live) begin
                    r_d.v1    = 1'b1;
                    r_d.first = 1'b0;
                    for (int r = 0; r < Q; r++) begin
                        r_d.syn1[r]  = (r_q.first && (QB'(r) > r_q.lmod)) ? '0 : syn_rd[r];
                        r_d.coef1[r] = coef_rd[r];
                        if (!r_q.coef_addr[r][AW-1])
                            r_d.coef_addr[r] = r_q.coef_addr[r] - AW'(1);
                    end
                    if (!r_q.syn_addr[AW-1]) r_d.syn_addr = r_q.syn_addr - AW'(1);
                end else begin
                    r_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!r_q.v1 && !r_q.v2) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                    r_d.disc = r_q.acc;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // Pipeline: read registers -> rotator/syndrome delay -> accumulator.
        r_d.v2 = r_q.v1;
        if (r_q.v1) r_d.syn2 = r_q.syn1;
        if (r_q.v2) r_d.acc  = r_q.acc ^ lane_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = r_q.busy;
    assign done = r_q.done;
    assign disc = r_q.disc;
endmodule

// File: rtl/dd_disc_chk.sv
module dd_disc_chk #(
    parameter int Q = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [3:0]           disc,
    input logic [$clog2(Q)-1:0] rot_amt
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_disc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(disc));

    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_rot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rot_amt));
endmodule

bind dd_disc_unit dd_disc_chk #(.Q(Q)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .disc    (disc),
    .rot_amt (rot_amt)
);

// File: tb/dd_disc_unit_test.sv
module dd_disc_unit_test;
    localparam int Q     = 4;
    localparam int DEPTH = 16;
    localparam int N     = Q * DEPTH;
    localparam int IW    = $clog2(N);

    // Each entry: {iter_l, order_o}
    localparam logic [11:0] VEC [10] = '{
        {6'd34, 6'd20},   // R3 reference iteration, span residue 2
        {6'd17, 6'd5 },   // R3 span multiple of Q
        {6'd40, 6'd39},   // R6 span 1
        {6'd51, 6'd28},   // R3 span residue 3
        {6'd29, 6'd3 },   // R5 l mod Q = 1
        {6'd12, 6'd12},   // R9 order equals l
        {6'd0,  6'd0 },   // R9 single term at index 0
        {6'd63, 6'd63},   // R9 full range
        {6'd63, 6'd0 },   // R9 order zero at maximum l
        {6'd9,  6'd2 }    // R6 span 7
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_coef = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [3:0]    wr_data = '0;
    logic          start = 1'b0;
    logic [IW-1:0] iter_l = '0;
    logic [IW-1:0] order_o = '0;
    logic          busy, done;
    logic [3:0]    disc;

    logic [3:0] sy [N];
    logic [3:0] cf [N];
    int nchk = 0;
    int nerr = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    dd_disc_unit #(.Q(Q), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_coef(wr_coef),
        .wr_idx(wr_idx), .wr_data(wr_data), .start(start),
        .iter_l(iter_l), .order_o(order_o),
        .busy(busy), .done(done), .disc(disc)
    );

    function automatic logic [3:0] ref_mul(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] x = a;
        logic [3:0] acc = 4'h0;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[3] ? ((x << 1) ^ 4'h3) : (x << 1);
        end
        return acc;
    endfunction

    function automatic logic [3:0] model(input int l, input int o);
        logic [3:0] acc = 4'h0;
        for (int k = 0; k <= o; k++) acc = acc ^ ref_mul(cf[k], sy[l - o + k]);
        return acc;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit coef, input int idx, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_coef = coef; wr_idx = IW'(idx); wr_data = d;
        if (coef) cf[idx] = d; else sy[idx] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic next_rand(output logic [3:0] v);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v = lfsr[3:0] ^ lfsr[11:8];
    endtask

    task automatic run(input int l, input int o, output logic [3:0] res, output bit ok);
        int n = 0;
        @(negedge clk);
        start = 1'b1; iter_l = IW'(l); order_o = IW'(o);
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        ok = done;
        res = disc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL R7 watchdog actual=no_finish expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [3:0] v, res, keep;
        bit ok;

        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {3'b0, busy}, 4'h0);
        chk("R1 done in reset", {3'b0, done}, 4'h0);
        chk("R1 disc in reset", disc, 4'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 busy after reset", {3'b0, busy}, 4'h0);
        chk("R1 disc after reset", disc, 4'h0);

        // R4: fill both memories through the write port
        for (int i = 0; i < N; i++) begin
            next_rand(v); wr(1'b0, i, v);
            next_rand(v); wr(1'b1, i, v);
        end

        // Table walk: R3, R4, R5, R6, R9
        for (int t = 0; t < 10; t++) begin
            int l = int'(VEC[t][11:6]);
            int o = int'(VEC[t][5:0]);
            run(l, o, res, ok);
            chk($sformatf("R7 done seen l=%0d o=%0d", l, o), {3'b0, ok}, 4'h1);
            chk($sformatf("R3 R9 result l=%0d o=%0d", l, o), res, model(l, o));
            @(negedge clk);
            chk("R7 done single cycle", {3'b0, done}, 4'h0);
        end

        // R5: change values beyond o and beyond l, result must not move
        run(34, 20, keep, ok);
        wr(1'b1, 21, ~cf[21]); wr(1'b1, 22, ~cf[22]); wr(1'b1, 23, ~cf[23]);
        wr(1'b0, 35, ~sy[35]);
        run(34, 20, res, ok);
        chk("R5 masked lanes", res, keep);

        // R6: syndromes below c must not matter (l=9, o=2, c=7)
        run(9, 2, keep, ok);
        wr(1'b0, 6, ~sy[6]); wr(1'b0, 5, ~sy[5]); wr(1'b0, 4, ~sy[4]);
        run(9, 2, res, ok);
        chk("R6 below span ignored", res, keep);

        // R2: known field product 0x2 * 0x9 = 0x1
        wr(1'b1, 0, 4'h2); wr(1'b0, 10, 4'h9);
        run(10, 0, res, ok);
        chk("R2 product 2*9", res, 4'h1);

        // R8: busy after start, second start while busy ignored
        @(negedge clk);
        start = 1'b1; iter_l = 6'd34; order_o = 6'd20;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", {3'b0, busy}, 4'h1);
        start = 1'b1; iter_l = 6'd10; order_o = 6'd0;
        @(negedge clk);
        start = 1'b0;
        begin
            int n = 0;
            while (!done && n < 500) begin
                @(negedge clk);
                n++;
            end
        end
        chk("R8 busy low at done", {3'b0, busy}, 4'h0);
        chk("R8 start while busy ignored", disc, model(34, 20));
        keep = disc;
        repeat (4) @(negedge clk);
        chk("R7 disc held", disc, keep);
        chk("R8 no restart", {3'b0, busy}, 4'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule